// File: doc/BRIEF.md
# Receive Resource Ring Fetcher

This block keeps the receive side of a network controller supplied with buffer space. Buffer descriptors sit in a circular area of memory. Each descriptor holds a buffer start address and the buffer size in words. When the block is told to, it reads the next descriptor through a simple word-read port. It loads the address into the current-buffer address register and the size into the current word-count register. It then moves its ring read pointer on.

The block owns the ring geometry: an upper address half shared by the whole ring, the ring start and end, the read pointer and the host's write pointer. The ring does not wrap by a size. It wraps when the advanced read pointer lands exactly on the end address. The block flags that the ring has run dry when the read pointer, after any wrap, meets the write pointer.

A fetch can be started in three ways. The host can issue a fetch command. The host can clear the exhausted flag. The receive path can report a stored packet that left less room than the end-of-buffer threshold. A second data-width mode doubles the spacing of descriptor fields.

Top module: `rx_ring_fetch`

## Requirements
- R1: After reset the block is idle, `mem_req` is low, and `rd_ptr`, `buf_addr`, `buf_words` and `res_exhausted` are all zero.
- R2: In narrow mode a fetch issues four reads. Their addresses are {upper, rd_ptr} plus 0, 2, 4 and 6, in that order.
- R3: In wide mode (`cfg_wide`=1) the four reads are at offsets 0, 4, 8 and 12. Only the low 16 bits returned for each read are used, and the read pointer advances by 16.
- R4: On completion, `buf_addr` equals {second word, first word} and `buf_words` equals {fourth word, third word}.
- R5: On completion in narrow mode, `rd_ptr` advances by 8.
- R6: If the advanced pointer equals the ring end, `rd_ptr` is reloaded with the ring start.
- R7: `res_exhausted` is set on completion when the final `rd_ptr` equals the write pointer. It stays set until the host clears it.
- R8: `mem_req` is held, with a stable address, until `mem_ack`, whatever the latency. `fetch_busy` is high from the first read until the completion cycle.
- R9: Pulsing `exh_clr` while `res_exhausted` is set clears the flag and starts a fetch. The same pulse while the flag is clear has no effect on the ring pointer.
- R10: `rx_stored` starts a fetch only if the 32-bit `rx_left` is strictly below the end-of-buffer threshold, which resets to 0x02F8.
- R11: Triggers that arrive while a fetch is in progress collapse into one pending fetch. That fetch starts after the current one completes.
- R12: Writes to the start, end, read and write pointers (register selects 1 to 4) force bit 0 to zero. Select 0 sets the upper address half and select 5 sets the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1 selects 32-bit field spacing |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 upper, 1 start, 2 end, 3 read ptr, 4 write ptr, 5 threshold |
| reg_wdata | input | 16 | Register write data |
| cmd_fetch | input | 1 | Host fetch command pulse |
| exh_clr | input | 1 | Host clear of the exhausted flag |
| rx_stored | input | 1 | Receive path stored a packet |
| rx_left | input | 32 | Words remaining in the current buffer |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 16 | Memory read data |
| fetch_busy | output | 1 | Fetch in progress |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Current buffer word count |
| rd_ptr | output | 16 | Ring read pointer |
| res_exhausted | output | 1 | Ring resources exhausted |

## Verification
The bench aims at the fetch that lands on the ring end. A design that wrapped by a size or compared before advancing would leave the pointer on the end address or wrap one descriptor early. It also clears the exhausted flag while the flag is low; a design that treated any clear as a trigger would advance the ring unprompted. It sets the remaining count exactly equal to the threshold and also above 16 bits; a wrong compare would fetch on equality or would look only at the low half. It bursts commands into a busy fetch; a design without a pending latch would lose the second fetch, and one that counted triggers would fetch too often. A wide-mode pass catches a design that kept the narrow field spacing.

// File: rtl/rrf_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the receive resource ring fetcher.
package rrf_pkg;
    // Fetch sequencer states.
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_READ   = 2'd1,
        SQ_COMMIT = 2'd2
    } seq_state_t;

    // Fields per descriptor: addr low, addr high, count low, count high.
    localparam int unsigned NUM_FIELDS = 4;

    // Host register selects.
    localparam logic [2:0] SEL_UPPER = 3'd0;
    localparam logic [2:0] SEL_START = 3'd1;
    localparam logic [2:0] SEL_END   = 3'd2;
    localparam logic [2:0] SEL_RDPTR = 3'd3;
    localparam logic [2:0] SEL_WRPTR = 3'd4;
    localparam logic [2:0] SEL_EOB   = 3'd5;
endpackage

// File: rtl/rrf_trigger.sv
`timescale 1ns/1ps
// Trigger arbiter. Merges the three fetch sources into one start pulse.
// A source seen while the sequencer is busy is held in a single pending
// bit. Assumes seq_idle comes from registered state, so no loop exists.
module rrf_trigger #(
    parameter int unsigned W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_fetch,
    input  logic           exh_clr,
    input  logic           exh_q,
    input  logic           rx_stored,
    input  logic [2*W-1:0] rx_left,
    input  logic [W-1:0]   eob,
    input  logic           seq_idle,
    output logic           start
);
    localparam int unsigned LW = 2*W;

    logic fire;
    logic low_room;
    logic pend_q;

    // Room check: the remaining count is strictly below the threshold.
    assign low_room = rx_left < LW'(eob);
    // Any trigger source this cycle. A clear counts only if the flag was set.
    assign fire  = cmd_fetch | (exh_clr & exh_q) | (rx_stored & low_room);
    // Launch when idle and there is new or held work.
    assign start = seq_idle & (fire | pend_q);

    // Hold one trigger while busy; drop it when a fetch launches.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (seq_idle) pend_q <= 1'b0;
        else if (fire)     pend_q <= 1'b1;
    end

    AST_PEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(!seq_idle)); // R11
    AST_PEND_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && seq_idle) |-> start); // R11
endmodule

// File: rtl/rrf_seq.sv
`timescale 1ns/1ps
// Fetch sequencer. Issues one read per descriptor field and holds each
// request until it is acknowledged. It captures the fields and pulses
// commit once all are in. Assumes the ring pointers are not written
// while a fetch is in progress.
module rrf_seq #(
    parameter int unsigned W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              wide,
    input  logic [W-1:0]                      upper,
    input  logic [W-1:0]                      rdptr,
    input  logic                              mem_ack,
    input  logic [W-1:0]                      mem_rdata,
    output logic                              mem_req,
    output logic [2*W-1:0]                    mem_addr,
    output logic                              busy,
    output logic                              idle,
    output logic                              commit,
    output logic [rrf_pkg::NUM_FIELDS*W-1:0]  fields
);
    import rrf_pkg::*;

    localparam int unsigned AW = 2*W;
    localparam int unsigned FW = $clog2(NUM_FIELDS);

    seq_state_t     st_q, st_d;
    logic [FW-1:0]  fld_q;
    logic [AW-1:0]  off;
    logic           last_fld;
    logic           take;

    assign last_fld = (fld_q == FW'(NUM_FIELDS-1));
    assign take     = (st_q == SQ_READ) && mem_ack;

    // Field offset: two bytes per field when narrow, four when wide.
    always_comb off = wide ? (AW'(fld_q) << 2) : (AW'(fld_q) << 1);

    assign mem_addr = {upper, rdptr} + off;
    assign mem_req  = (st_q == SQ_READ);
    assign busy     = (st_q != SQ_IDLE);
    assign idle     = (st_q == SQ_IDLE);
    assign commit   = (st_q == SQ_COMMIT);

    // Next-state selection for the read sequence.
    always_comb begin
        st_d = st_q;
        case (st_q)
            SQ_IDLE:   if (start) st_d = SQ_READ;
            SQ_READ:   if (take && last_fld) st_d = SQ_COMMIT;
            SQ_COMMIT: st_d = SQ_IDLE;
            default:   st_d = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    // Field index: reset at launch, stepped on each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)                fld_q <= '0;
        else if (start)            fld_q <= '0;
        else if (take && !last_fld) fld_q <= fld_q + 1'b1;
    end

    // One capture register per field.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cap
        logic [W-1:0] sh_q;
        // Latch this field's word when its read is acknowledged.
        always_ff @(posedge clk) begin
            if (!rst_n)                            sh_q <= '0;
            else if (take && fld_q == FW'(g))      sh_q <= mem_rdata;
        end
        assign fields[g*W +: W] = sh_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R8
    AST_DONE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(commit)); // R8
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, commit})); // R8
endmodule

// File: rtl/rrf_ring.sv
`timescale 1ns/1ps
// Ring state. Holds the host-programmed ring geometry, the read pointer,
// the current buffer registers and the exhausted flag. On commit it loads
// the buffer, advances the pointer by one descriptor, wraps on equality
// with the end and checks against the write pointer.
module rrf_ring #(
    parameter int unsigned W         = 16,
    parameter logic [15:0] EOB_RESET = 16'h02F8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic [2:0]                        reg_sel,
    input  logic [W-1:0]                      reg_wdata,
    input  logic                              wide,
    input  logic                              commit,
    input  logic [rrf_pkg::NUM_FIELDS*W-1:0]  fields,
    input  logic                              exh_clr,
    output logic [W-1:0]                      upper,
    output logic [W-1:0]                      rdptr,
    output logic [W-1:0]                      eob,
    output logic [2*W-1:0]                    buf_addr,
    output logic [2*W-1:0]                    buf_words,
    output logic                              exhausted
);
    import rrf_pkg::*;

    localparam logic [W-1:0] EVEN_MASK   = ~W'(1);
    localparam logic [W-1:0] STEP_NARROW = W'(2*NUM_FIELDS);
    localparam logic [W-1:0] STEP_WIDE   = W'(4*NUM_FIELDS);

    logic [W-1:0] start_q, end_q, wr_q;
    logic [W-1:0] adv, nxt;
    logic         wr_even;

    assign wr_even = reg_wr && (reg_sel == SEL_START || reg_sel == SEL_END ||
                                reg_sel == SEL_RDPTR || reg_sel == SEL_WRPTR);

    // Pointer after one descriptor, then wrapped on an exact end match.
    always_comb begin
        adv = rdptr + (wide ? STEP_WIDE : STEP_NARROW);
        nxt = (adv == end_q) ? start_q : adv;
    end

    // Host-owned geometry and threshold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper   <= '0;
            start_q <= '0;
            end_q   <= '0;
            wr_q    <= '0;
            eob     <= W'(EOB_RESET);
        end else if (reg_wr) begin
            case (reg_sel)
                SEL_UPPER: upper   <= reg_wdata;
                SEL_START: start_q <= reg_wdata & EVEN_MASK;
                SEL_END:   end_q   <= reg_wdata & EVEN_MASK;
                SEL_WRPTR: wr_q    <= reg_wdata & EVEN_MASK;
                SEL_EOB:   eob     <= reg_wdata;
                default:   ;
            endcase
        end
    end

    // Read pointer: advance on commit, otherwise take host writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                              rdptr <= '0;
        else if (commit)                         rdptr <= nxt;
        else if (reg_wr && reg_sel == SEL_RDPTR) rdptr <= reg_wdata & EVEN_MASK;
    end

    // Current buffer registers, loaded from the captured descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_addr  <= '0;
            buf_words <= '0;
        end else if (commit) begin
            buf_addr  <= {fields[1*W +: W], fields[0*W +: W]};
            buf_words <= {fields[3*W +: W], fields[2*W +: W]};
        end
    end

    // Exhausted flag: set when the pointer meets the writer, cleared by host.
    always_ff @(posedge clk) begin
        if (!rst_n)                        exhausted <= 1'b0;
        else if (commit && (nxt == wr_q))  exhausted <= 1'b1;
        else if (exh_clr)                  exhausted <= 1'b0;
    end

    AST_EXH_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exhausted) |-> $past(commit)); // R7
    AST_WRAP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !reg_wr && (start_q != end_q)) |=> (rdptr != end_q)); // R6
    AST_PTR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rdptr[0] == 1'b0) && (start_q[0] == 1'b0) && (end_q[0] == 1'b0)); // R12
    AST_WR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_even |=> (wr_q[0] == 1'b0)); // R12
endmodule

// File: rtl/rx_ring_fetch.sv
`timescale 1ns/1ps
// Receive resource ring fetcher, top level. Joins the trigger arbiter,
// the fetch sequencer and the ring state. One fetch is in progress at a
// time. Memory reads use a request/acknowledge handshake of any latency.
module rx_ring_fetch #(
    parameter int unsigned W         = 16,
    parameter logic [15:0] EOB_RESET = 16'h02F8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wide,
    input  logic           reg_wr,
    input  logic [2:0]     reg_sel,
    input  logic [W-1:0]   reg_wdata,
    input  logic           cmd_fetch,
    input  logic           exh_clr,
    input  logic           rx_stored,
    input  logic [2*W-1:0] rx_left,
    output logic           mem_req,
    output logic [2*W-1:0] mem_addr,
    input  logic           mem_ack,
    input  logic [W-1:0]   mem_rdata,
    output logic           fetch_busy,
    output logic [2*W-1:0] buf_addr,
    output logic [2*W-1:0] buf_words,
    output logic [W-1:0]   rd_ptr,
    output logic           res_exhausted
);
    import rrf_pkg::*;

    logic                    start, idle, commit;
    logic [W-1:0]            upper, eob;
    logic [NUM_FIELDS*W-1:0] fields;

    rrf_trigger #(.W(W)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_fetch (cmd_fetch),
        .exh_clr   (exh_clr),
        .exh_q     (res_exhausted),
        .rx_stored (rx_stored),
        .rx_left   (rx_left),
        .eob       (eob),
        .seq_idle  (idle),
        .start     (start)
    );

    rrf_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wide      (cfg_wide),
        .upper     (upper),
        .rdptr     (rd_ptr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .busy      (fetch_busy),
        .idle      (idle),
        .commit    (commit),
        .fields    (fields)
    );

    rrf_ring #(.W(W), .EOB_RESET(EOB_RESET)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .wide      (cfg_wide),
        .commit    (commit),
        .fields    (fields),
        .exh_clr   (exh_clr),
        .upper     (upper),
        .rdptr     (rd_ptr),
        .eob       (eob),
        .buf_addr  (buf_addr),
        .buf_words (buf_words),
        .exhausted (res_exhausted)
    );

    AST_ACK_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && fetch_busy) |-> mem_req); // R8
endmodule

// File: tb/tb_rx_ring_fetch.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model compared every clock, plus directed checks.
module tb_rx_ring_fetch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic        cmd_fetch = 1'b0;
    logic        exh_clr = 1'b0;
    logic        rx_stored = 1'b0;
    logic [31:0] rx_left = 32'h0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'h0;
    logic        fetch_busy;
    logic [31:0] buf_addr, buf_words;
    logic [15:0] rd_ptr;
    logic        res_exhausted;

    int n_chk = 0;
    int n_bad = 0;
    int lat = 0;
    int ack_cnt = 0;
    int busy_rises = 0;
    logic prev_busy = 1'b0;
    logic [31:0] alog[$];

    always #4 clk = ~clk;

    rx_ring_fetch dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .cmd_fetch(cmd_fetch),
        .exh_clr(exh_clr), .rx_stored(rx_stored), .rx_left(rx_left),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .fetch_busy(fetch_busy), .buf_addr(buf_addr),
        .buf_words(buf_words), .rd_ptr(rd_ptr), .res_exhausted(res_exhausted)
    );

    function automatic logic [15:0] mword(input logic [31:0] a);
        return a[15:0] ^ 16'h3C5A ^ {a[23:16], a[31:24]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder, driven at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; ack_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0; ack_cnt = 0;
        end else if (mem_req) begin
            if (ack_cnt >= lat) begin
                mem_ack = 1'b1;
                mem_rdata = mword(mem_addr);
                alog.push_back(mem_addr);
            end else ack_cnt++;
        end
        if (fetch_busy && !prev_busy) busy_rises++;
        prev_busy = fetch_busy;
    end

    // Behavioural reference model.
    logic [15:0] m_up, m_st, m_en, m_rd, m_wr, m_eob;
    logic [15:0] m_sh [4];
    logic [31:0] m_ba, m_bw;
    logic        m_pend, m_exh, m_fire;
    logic [15:0] m_adv, m_nxt;
    int          m_state, m_fld;
    bit          m_commit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_up = 0; m_st = 0; m_en = 0; m_rd = 0; m_wr = 0; m_eob = 16'h02F8;
            m_ba = 0; m_bw = 0; m_pend = 0; m_exh = 0; m_state = 0; m_fld = 0;
            for (int i = 0; i < 4; i++) m_sh[i] = 0;
        end else begin
            m_fire = cmd_fetch || (exh_clr && m_exh) ||
                     (rx_stored && (rx_left < {16'h0, m_eob}));
            m_commit = (m_state == 2);
            m_adv = m_rd + (cfg_wide ? 16'd16 : 16'd8);
            m_nxt = (m_adv == m_en) ? m_st : m_adv;
            if (m_commit) begin
                m_ba = {m_sh[1], m_sh[0]};
                m_bw = {m_sh[3], m_sh[2]};
                if (m_nxt == m_wr) m_exh = 1;
                else if (exh_clr) m_exh = 0;
            end else if (exh_clr) m_exh = 0;
            if (reg_wr) begin
                case (reg_sel)
                    3'd0: m_up = reg_wdata;
                    3'd1: m_st = reg_wdata & 16'hFFFE;
                    3'd2: m_en = reg_wdata & 16'hFFFE;
                    3'd3: if (!m_commit) m_rd = reg_wdata & 16'hFFFE;
                    3'd4: m_wr = reg_wdata & 16'hFFFE;
                    3'd5: m_eob = reg_wdata;
                    default: ;
                endcase
            end
            if (m_commit) m_rd = m_nxt;
            case (m_state)
                0: if (m_fire || m_pend) begin m_state = 1; m_fld = 0; m_pend = 0; end
                1: begin
                    if (m_fire) m_pend = 1;
                    if (mem_ack) begin
                        m_sh[m_fld] = mem_rdata;
                        if (m_fld == 3) m_state = 2; else m_fld++;
                    end
                end
                default: begin if (m_fire) m_pend = 1; m_state = 0; end
            endcase
        end
    end

    // Compare against the model shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        chk("R8 mem_req", mem_req, m_state == 1);
        chk("R8 fetch_busy", fetch_busy, m_state != 0);
        if (m_state == 1)
            chk("R2 mem_addr", mem_addr,
                {m_up, m_rd} + 32'(m_fld * (cfg_wide ? 4 : 2)));
        chk("R5 rd_ptr", rd_ptr, m_rd);
        chk("R4 buf_addr", buf_addr, m_ba);
        chk("R4 buf_words", buf_words, m_bw);
        chk("R7 res_exhausted", res_exhausted, m_exh);
    end

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic pulse_cmd();
        @(negedge clk); cmd_fetch = 1;
        @(negedge clk); cmd_fetch = 0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 4) begin
            @(negedge clk);
            if (fetch_busy) q = 0; else q++;
        end
    endtask

    task automatic chk_fetch(input string tag, input logic [31:0] base, input int step);
        chk({tag, " buf_addr"}, buf_addr, {mword(base + 32'(step)), mword(base)});
        chk({tag, " buf_words"}, buf_words,
            {mword(base + 32'(3*step)), mword(base + 32'(2*step))});
    endtask

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        chk("R1 busy", fetch_busy, 0);
        chk("R1 req", mem_req, 0);
        chk("R1 rd_ptr", rd_ptr, 0);
        chk("R1 exhausted", res_exhausted, 0);
        chk("R1 buf_addr", buf_addr, 0);
        chk("R1 buf_words", buf_words, 0);
        rst_n = 1;

        wr(3'd0, 16'h0012); wr(3'd1, 16'h0101); wr(3'd2, 16'h0120);
        wr(3'd3, 16'h0101); wr(3'd4, 16'h0119);
        @(negedge clk);
        chk("R12 rd_ptr odd write", rd_ptr, 16'h0100);

        alog.delete(); lat = 0;
        pulse_cmd(); wait_quiet();
        chk("R2 read count", alog.size(), 4);
        for (int i = 0; i < 4; i++)
            if (alog.size() > i) chk("R2 read addr", alog[i], 32'h00120100 + 32'(2*i));
        chk_fetch("R4", 32'h00120100, 2);
        chk("R5 advance", rd_ptr, 16'h0108);

        lat = 3;
        pulse_cmd(); wait_quiet();
        chk_fetch("R8 slow memory", 32'h00120108, 2);
        chk("R8 rd_ptr", rd_ptr, 16'h0110);
        lat = 1;
        pulse_cmd(); wait_quiet();
        chk("R7 rd_ptr meets writer", rd_ptr, 16'h0118);
        chk("R7 exhausted set", res_exhausted, 1);

        @(negedge clk); exh_clr = 1; @(negedge clk); exh_clr = 0;
        wait_quiet();
        chk("R6 wrap to start", rd_ptr, 16'h0100);
        chk("R9 flag cleared", res_exhausted, 0);

        r0 = busy_rises;
        @(negedge clk); exh_clr = 1; @(negedge clk); exh_clr = 0;
        repeat (6) @(negedge clk);
        chk("R9 clear when low no fetch", busy_rises, r0);
        chk("R9 rd_ptr unchanged", rd_ptr, 16'h0100);

        rx_left = 32'h000002F8;
        @(negedge clk); rx_stored = 1; @(negedge clk); rx_stored = 0;
        wait_quiet();
        chk("R10 equal threshold no fetch", rd_ptr, 16'h0100);
        rx_left = 32'h00010000;
        @(negedge clk); rx_stored = 1; @(negedge clk); rx_stored = 0;
        wait_quiet();
        chk("R10 high half counts", rd_ptr, 16'h0100);
        rx_left = 32'h000002F7;
        @(negedge clk); rx_stored = 1; @(negedge clk); rx_stored = 0;
        wait_quiet();
        chk("R10 below threshold fetch", rd_ptr, 16'h0108);

        r0 = busy_rises;
        pulse_cmd(); pulse_cmd(); pulse_cmd();
        wait_quiet();
        chk("R11 fetches", busy_rises - r0, 2);
        chk("R11 rd_ptr", rd_ptr, 16'h0118);

        cfg_wide = 1;
        wr(3'd1, 16'h0200); wr(3'd2, 16'h0220); wr(3'd3, 16'h0200); wr(3'd4, 16'h0400);
        alog.delete(); lat = 0;
        pulse_cmd(); wait_quiet();
        chk("R3 read count", alog.size(), 4);
        for (int i = 0; i < 4; i++)
            if (alog.size() > i) chk("R3 read addr", alog[i], 32'h00120200 + 32'(4*i));
        chk_fetch("R3", 32'h00120200, 4);
        chk("R3 wide advance", rd_ptr, 16'h0210);
        pulse_cmd(); wait_quiet();
        chk("R6 wide wrap", rd_ptr, 16'h0200);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog run did not finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule